// File: doc/BRIEF.md
# Keyed Software Watchdog Timer

This block is a watchdog down-counter that software keeps alive by writing two fixed 16-bit key words, in order, to one service register. The counter is decremented once per prescaled tick. If it reaches its end before a complete key pair arrives, the block raises a one-cycle timeout pulse. It then reloads itself and keeps counting. A downstream reset generator or interrupt controller can consume that pulse.

Access goes through a single-cycle register port with address, write data, write strobe, read strobe and read data. Only the service address takes part. A write there moves a small key tracker forward. When the second key lands while the tracker is armed, the counter and the prescaler both restart from their full values. The service register is write-only, and every read returns zero. An enable input freezes the whole block: the count, the prescale phase and the tracker all hold, and writes are dropped.

Top module: `wdt_keyed_top`

## Requirements
- R1: Reset drives timeout low, loads the full count and disarms the key tracker. With enable high and no service, the first timeout pulse is seen exactly PERIOD*PRESCALE enabled clocks after reset release.
- R2: Without service, timeout is high for exactly one clock every PERIOD*PRESCALE enabled clocks, because the counter reloads itself after each expiry.
- R3: A write of KEY_FIRST (default 0x556C) followed by a write of KEY_SECOND (default 0xAA39) to SVC_ADDR restarts the counter and prescaler. The next timeout then comes PERIOD*PRESCALE clocks after the clock edge that took the second key.
- R4: A KEY_SECOND write whose most recent earlier service write was not KEY_FIRST causes no restart.
- R5: A service write of any value other than the expected key disarms the tracker, so a following KEY_SECOND causes no restart.
- R6: Repeated KEY_FIRST writes keep the tracker armed, so a later KEY_SECOND still restarts the count.
- R7: A service that completes on the same clock edge on which the count would expire wins. No timeout pulse is produced, and the count restarts.
- R8: While enable is low, the count and the prescale phase hold, timeout stays low, writes are ignored and the tracker keeps its state.
- R9: Read data is always zero, whatever was written before.
- R10: Writes to any address other than SVC_ADDR have no effect on the tracker or the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low freezes counting and ignores writes |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| wr | input | 1 | Write strobe, one access per clock |
| rd | input | 1 | Read strobe |
| rdata | output | DATA_W | Read data, always zero |
| timeout | output | 1 | One-clock expiry pulse |

## Verification
The hardest case to reach is a second key that lands on exactly the clock edge where the count would otherwise expire. The bench keeps an arithmetic count of enabled clocks since the last reload. It idles until that count is two short of PERIOD*PRESCALE, then issues the first key and the second key on consecutive clocks, so the second key coincides with expiry. The same running count also predicts every other pulse position, including after enable-low stretches that must freeze the prescale phase mid-period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam logic [15:0] WDT_KEY_FIRST_DEF  = 16'h556C;
   localparam logic [15:0] WDT_KEY_SECOND_DEF = 16'hAA39;

   typedef enum logic {
      TRK_WAIT  = 1'b0,
      TRK_ARMED = 1'b1
   } trk_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRESCALE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);
   generate
      if (PRESCALE < 1) begin : g_bad
         $error("wdt_prescaler: PRESCALE must be at least 1");
      end
      if (PRESCALE == 1) begin : g_direct
         assign tick = en & ~clr;
      end else begin : g_count
         localparam int PRE_W = $clog2(PRESCALE);
         localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);
         logic [PRE_W-1:0] phase;

         assign tick = en & ~clr & (phase == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (clr) begin
               phase <= '0;
            end else if (en) begin
               phase <= (phase == LAST) ? '0 : phase + 1'b1;
            end
         end

         assert_phase_frozen_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            (!en && !clr) |=> $stable(phase));
      end
   endgenerate

   assert_tick_idle_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !tick);
endmodule

// File: rtl/wdt_key_tracker.sv
module wdt_key_tracker
   import wdt_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter logic [15:0] KEY_FIRST  = WDT_KEY_FIRST_DEF,
   parameter logic [15:0] KEY_SECOND = WDT_KEY_SECOND_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [DATA_W-1:0] wdata,
   output logic              service
);
   localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

   generate
      if (K1 == K2) begin : g_bad_keys
         $error("wdt_key_tracker: the two keys must differ");
      end
   endgenerate

   trk_state_e state;
   logic       is_first;
   logic       is_second;

   assign is_first  = (wdata == K1);
   assign is_second = (wdata == K2);
   assign service   = wr_ok & is_second & (state == TRK_ARMED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TRK_WAIT;
      end else if (wr_ok) begin
         state <= is_first ? TRK_ARMED : TRK_WAIT;
      end
   end

   assert_service_armed_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      service |-> (state == TRK_ARMED));
   assert_reject_clears_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !is_first) |=> (state == TRK_WAIT));
   assert_first_arms_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && is_first) |=> (state == TRK_ARMED));
   assert_idle_holds_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(state));
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int PERIOD = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic reload,
   output logic expire
);
   localparam int CNT_W = $clog2(PERIOD + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(PERIOD);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   generate
      if (PERIOD < 2) begin : g_bad
         $error("wdt_down_counter: PERIOD must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= FULL;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (reload) begin
            cnt <= FULL;
         end else if (tick) begin
            if (cnt == ONE) begin
               cnt    <= FULL;
               expire <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assert_pulse_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
   assert_reload_full_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt == FULL && !expire));
   assert_count_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) && (cnt <= FULL));
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
   import wdt_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter int          ADDR_W     = 4,
   parameter int          SVC_ADDR   = 14,
   parameter int          PERIOD     = 1024,
   parameter int          PRESCALE   = 16,
   parameter logic [15:0] KEY_FIRST  = WDT_KEY_FIRST_DEF,
   parameter logic [15:0] KEY_SECOND = WDT_KEY_SECOND_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata,
   output logic              timeout
);
   localparam logic [ADDR_W-1:0] SVC   = ADDR_W'(SVC_ADDR);
   localparam logic [DATA_W-1:0] RD_VAL = '0;

   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("wdt_keyed_top: DATA_W must hold a 16-bit key");
      end
      if (SVC_ADDR < 0 || SVC_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("wdt_keyed_top: SVC_ADDR outside the address range");
      end
   endgenerate

   logic hit;
   logic wr_ok;
   logic service;
   logic tick;

   assign hit   = (addr == SVC);
   assign wr_ok = wr & en & hit;
   assign rdata = (rd & hit) ? RD_VAL : '0;

   wdt_key_tracker #(
      .DATA_W    (DATA_W),
      .KEY_FIRST (KEY_FIRST),
      .KEY_SECOND(KEY_SECOND)
   ) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ok  (wr_ok),
      .wdata  (wdata),
      .service(service)
   );

   wdt_prescaler #(
      .PRESCALE(PRESCALE)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .clr  (service),
      .tick (tick)
   );

   wdt_down_counter #(
      .PERIOD(PERIOD)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .reload(service),
      .expire(timeout)
   );

   assert_service_masks_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      service |=> !timeout);
   assert_disabled_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !timeout);
   assert_foreign_addr_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> !service);
endmodule

// File: tb/sim_wdt_keyed_top.sv
module sim_wdt_keyed_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int SVC = 6;
   localparam int PER = 4;
   localparam int PRE = 3;
   localparam int NP = PER * PRE;
   localparam logic [15:0] K1 = 16'h556C;
   localparam logic [15:0] K2 = 16'hAA39;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          wr = 1'b0;
   logic          rd = 1'b0;
   logic [DW-1:0] rdata;
   logic          timeout;

   int nchk = 0;
   int nerr = 0;
   int since = 0;
   logic exp_to = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wdt_keyed_top #(
      .DATA_W(DW), .ADDR_W(AW), .SVC_ADDR(SVC),
      .PERIOD(PER), .PRESCALE(PRE), .KEY_FIRST(K1), .KEY_SECOND(K2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .addr(addr), .wdata(wdata),
      .wr(wr), .rd(rd), .rdata(rdata), .timeout(timeout)
   );

   task automatic check(input string tag, input int act, input int expv);
      nchk++;
      if (act != expv) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
      end
   endtask

   // one clock: optional write, model update from enabled clocks since reload
   task automatic cyc(input logic w, input logic [15:0] d, input int a,
                      input logic rel, input string tag);
      wr = w; wdata = d; addr = AW'(a);
      @(posedge clk);
      exp_to = 1'b0;
      if (en) begin
         if (rel) since = 0;
         else begin
            since++;
            if (since == NP) begin
               exp_to = 1'b1;
               since = 0;
            end
         end
      end
      @(negedge clk);
      wr = 1'b0;
      check(tag, int'(timeout), int'(exp_to));
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 0, 1'b0, tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #(CLK_PERIOD * 2);
      @(negedge clk);
      check("R1 reset timeout", int'(timeout), 0);
      rst_n = 1'b1;
      since = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      @(negedge clk);
      check("R1 reset timeout", int'(timeout), 0);
      check("R9 reset rdata", int'(rdata), 0);
      rst_n = 1'b1;
      en = 1'b1;
      idle(NP, "R1 first expiry");
      idle(2 * NP + 3, "R2 free run");

      // R3 basic service mid-count
      cyc(1'b1, K1, SVC, 1'b0, "R3 key1");
      cyc(1'b1, K2, SVC, 1'b1, "R3 key2");
      idle(NP + 2, "R3 after service");

      // R4 second key alone
      cyc(1'b1, K2, SVC, 1'b0, "R4 lone key2");
      idle(NP, "R4 after");

      // R5 single-bit corruptions of the first key between keys
      for (int b = 0; b < 16; b++) begin
         cyc(1'b1, K1, SVC, 1'b0, "R5 key1");
         cyc(1'b1, K1 ^ (16'h1 << b), SVC, 1'b0, "R5 junk");
         cyc(1'b1, K2, SVC, 1'b0, "R5 key2 rejected");
      end
      idle(NP, "R5 after");

      // R6 repeated first key
      cyc(1'b1, K1, SVC, 1'b0, "R6 key1");
      cyc(1'b1, K1, SVC, 1'b0, "R6 key1 again");
      cyc(1'b1, K1, SVC, 1'b0, "R6 key1 third");
      cyc(1'b1, K2, SVC, 1'b1, "R6 key2");
      idle(NP, "R6 after");

      // R10 other addresses
      for (int a = 0; a < 16; a++) begin
         if (a != SVC) begin
            cyc(1'b1, K1, a, 1'b0, "R10 key1 foreign");
            cyc(1'b1, K2, a, 1'b0, "R10 key2 foreign");
         end
      end
      cyc(1'b1, K1, SVC, 1'b0, "R10 key1");
      cyc(1'b1, 16'h0BAD, (SVC + 1) % 16, 1'b0, "R10 junk foreign");
      cyc(1'b1, K2, SVC, 1'b1, "R10 armed survives");
      idle(NP, "R10 after");

      // R9 reads return zero, and a read between keys does not disarm
      cyc(1'b1, K1, SVC, 1'b0, "R9 key1");
      rd = 1'b1;
      for (int a = 0; a < 16; a++) begin
         addr = AW'(a);
         #1;
         check("R9 rdata", int'(rdata), 0);
      end
      cyc(1'b0, 16'h0, SVC, 1'b0, "R9 read cycle");
      check("R9 rdata after key1", int'(rdata), 0);
      rd = 1'b0;
      cyc(1'b1, K2, SVC, 1'b1, "R9 key2");
      idle(NP, "R9 after");

      // R7 service on the expiring edge
      while (since != NP - 2) idle(1, "R7 align");
      cyc(1'b1, K1, SVC, 1'b0, "R7 key1");
      cyc(1'b1, K2, SVC, 1'b1, "R7 service beats expiry");
      idle(NP + 1, "R7 after");

      // R8 enable low freezes mid-period, writes ignored
      idle(5, "R8 pre");
      en = 1'b0;
      cyc(1'b1, K1, SVC, 1'b0, "R8 key1 disabled");
      cyc(1'b1, K2, SVC, 1'b0, "R8 key2 disabled");
      idle(2 * NP, "R8 frozen");
      en = 1'b1;
      idle(NP + 2, "R8 resume");
      cyc(1'b1, K1, SVC, 1'b0, "R8 arm");
      en = 1'b0;
      idle(4, "R8 armed frozen");
      en = 1'b1;
      cyc(1'b1, K2, SVC, 1'b1, "R8 armed kept");
      cyc(1'b1, 16'h1111, SVC, 1'b0, "R8 disarm");
      en = 1'b0;
      cyc(1'b1, K1, SVC, 1'b0, "R8 key1 ignored");
      en = 1'b1;
      cyc(1'b1, K2, SVC, 1'b0, "R8 still disarmed");
      idle(NP, "R8 after");

      // R1 reset clears an armed tracker
      cyc(1'b1, K1, SVC, 1'b0, "R1 arm before reset");
      do_reset();
      cyc(1'b1, K2, SVC, 1'b0, "R1 tracker cleared");
      idle(NP + 2, "R1 after reset");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule